// File: doc/BRIEF.md
# SHA-256 Message Schedule Extender

This block produces one new 32-bit message-schedule word for SHA-256 from four earlier schedule words: the words two, seven, fifteen and sixteen positions back. It applies the two small sigma mixing functions, one to the word fifteen back and one to the word two back. It then adds those two results to the other two operands, modulo 2^32. It serves schedule positions 16 to 63 only. Positions 0 to 15 are raw message words and never pass through it.

The datapath is fully pipelined and takes a new, independent operand set on every clock cycle. The schedules of many messages can therefore be interleaved cycle by cycle. The latency is fixed at elaboration to either one register stage or three. A valid bit travels alongside the data through the same number of stages. The data registers carry no reset. The valid chain is cleared by an asynchronous active-low reset, so an output word has meaning only while its valid bit is high.

Top module: `msg_sched_ext`

## Requirements
- R1: The low sigma function of the word fifteen back equals the XOR of that word rotated right by 7, the same word rotated right by 18, and the same word logically shifted right by 3.
- R2: The low sigma function of the word two back equals the XOR of that word rotated right by 17, the same word rotated right by 19, and the same word logically shifted right by 10.
- R3: The output word equals the word sixteen back, plus the word seven back, plus both sigma results, truncated to 32 bits. Carries out of bit 31 are discarded, for example when every operand is all ones.
- R4: An operand set sampled at a rising edge while in_valid is high produces its result on w_new exactly LATENCY rising edges later. It is visible after edge number LATENCY-1 counted from the sampling edge, with LATENCY either 1 or 3.
- R5: A new operand set is accepted on every cycle. Back-to-back sets leave in the same order, one per cycle, and none is lost or merged.
- R6: out_valid is high in a cycle exactly when in_valid was high LATENCY edges earlier. Cycles with in_valid low produce no output.
- R7: While rst_n is low, out_valid is low, and it falls as soon as rst_n falls, without waiting for a clock edge. Operand sets in flight when reset is asserted never appear at the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the valid chain |
| in_valid | input | 1 | Operand set on the inputs is to be processed |
| w_m2 | input | 32 | Schedule word two positions back |
| w_m7 | input | 32 | Schedule word seven positions back |
| w_m15 | input | 32 | Schedule word fifteen positions back |
| w_m16 | input | 32 | Schedule word sixteen positions back |
| out_valid | output | 1 | w_new holds a result |
| w_new | output | 32 | Newly computed schedule word |

## Verification
The bench builds two copies of the block side by side from the same stimulus, one with LATENCY=3 and one with LATENCY=1. Both the split partial-sum pipeline and the single-stage adder are therefore checked against one reference for every item. Driving the same operand sets into both exposes ordering and latency slips in either variant. Isolated operands (only the word fifteen back or only the word two back non-zero) reach each sigma function on its own. All-ones sets reach the carry wraparound. A reset asserted with items still inside the three-stage pipeline shows that in-flight items are dropped.

// File: rtl/mse_pkg.sv
package mse_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t rotr(input word_t x, input int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  // low sigma applied to the word fifteen back
  function automatic word_t mix_far(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  // low sigma applied to the word two back
  function automatic word_t mix_near(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic word_t sched_word(input word_t m2, input word_t m7,
                                       input word_t m15, input word_t m16);
    return m16 + mix_far(m15) + m7 + mix_near(m2);
  endfunction
endpackage

// File: rtl/mse_valid_chain.sv
module mse_valid_chain #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vld_in,
  output logic vld_out
);
  logic [DEPTH-1:0] vld_q;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= {vld_q[DEPTH-2:0], vld_in};
      end
    end
  endgenerate

  assign vld_out = vld_q[DEPTH-1];

  // R7
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert (vld_out == 1'b0)
        else $error("valid chain not cleared by reset");
    end
  end
endmodule

// File: rtl/mse_datapath.sv
module mse_datapath
  import mse_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic  clk,
  input  word_t m2,
  input  word_t m7,
  input  word_t m15,
  input  word_t m16,
  output word_t result
);
  // sigma outputs brought out as named wires
  word_t far_mix_w, near_mix_w;
  assign far_mix_w  = mix_far(m15);
  assign near_mix_w = mix_near(m2);

  generate
    if (LATENCY == 1) begin : g_lat1
      word_t sum_q;
      always_ff @(posedge clk) sum_q <= m16 + far_mix_w + m7 + near_mix_w;
      assign result = sum_q;
    end else begin : g_lat3
      word_t w16_q, w7_q, fm_q, nm_q;
      word_t part_far_q, part_near_q;
      word_t sum_q;
      always_ff @(posedge clk) begin
        w16_q       <= m16;
        w7_q        <= m7;
        fm_q        <= far_mix_w;
        nm_q        <= near_mix_w;
        part_far_q  <= w16_q + fm_q;
        part_near_q <= w7_q + nm_q;
        sum_q       <= part_far_q + part_near_q;
      end
      assign result = sum_q;
    end
  endgenerate
endmodule

// File: rtl/msg_sched_ext.sv
module msg_sched_ext #(
  parameter int LATENCY = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] w_m2,
  input  logic [31:0] w_m7,
  input  logic [31:0] w_m15,
  input  logic [31:0] w_m16,
  output logic        out_valid,
  output logic [31:0] w_new
);
  localparam int DEPTH = (LATENCY == 1) ? 1 : 3;
  localparam int WARM_W = $clog2(DEPTH + 1);

  mse_datapath #(.LATENCY(DEPTH)) u_dp (
    .clk(clk), .m2(w_m2), .m7(w_m7), .m15(w_m15), .m16(w_m16), .result(w_new)
  );

  mse_valid_chain #(.DEPTH(DEPTH)) u_vc (
    .clk(clk), .rst_n(rst_n), .vld_in(in_valid), .vld_out(out_valid)
  );

  // cycles since reset, saturating at the pipeline depth
  logic [WARM_W-1:0] warm_q;
  logic              warm_w;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         warm_q <= '0;
    else if (warm_q != WARM_W'(DEPTH))  warm_q <= warm_q + 1'b1;
  end
  assign warm_w = (warm_q == WARM_W'(DEPTH));

  // R6
  valid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_w && out_valid) |-> $past(in_valid, DEPTH))
    else $error("output valid without matching input");

  // R5
  valid_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_w && $past(in_valid, DEPTH)) |-> out_valid)
    else $error("accepted input set lost");

  // R3 R4
  word_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_w && out_valid) |->
      (w_new == $past(mse_pkg::sched_word(w_m2, w_m7, w_m15, w_m16), DEPTH)))
    else $error("result word mismatch at fixed latency");
endmodule

// File: tb/msg_sched_ext_bench.sv
module msg_sched_ext_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] w_m2, w_m7, w_m15, w_m16;
  logic        ov3, ov1;
  logic [31:0] wn3, wn1;

  always #2 clk = ~clk;   // 250 MHz

  msg_sched_ext #(.LATENCY(3)) u_msg_sched_ext (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .w_m2(w_m2), .w_m7(w_m7), .w_m15(w_m15), .w_m16(w_m16),
    .out_valid(ov3), .w_new(wn3));

  msg_sched_ext #(.LATENCY(1)) u_msg_sched_ext_l1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .w_m2(w_m2), .w_m7(w_m7), .w_m15(w_m15), .w_m16(w_m16),
    .out_valid(ov1), .w_new(wn1));

  typedef struct {
    logic [31:0] word;
    int          tag;
    string       req;
  } exp_t;

  exp_t q3[$];
  exp_t q1[$];
  int cyc = 0;
  int errors = 0;
  int checks = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    logic [63:0] d;
    d = {x, x} >> n;
    return d[31:0];
  endfunction

  function automatic logic [31:0] ref_word(input logic [31:0] a2, input logic [31:0] a7,
                                           input logic [31:0] a15, input logic [31:0] a16);
    logic [31:0] f, n;
    logic [33:0] s;
    f = rr(a15, 7) ^ rr(a15, 18) ^ {3'b000, a15[31:3]};
    n = rr(a2, 17) ^ rr(a2, 19) ^ {10'd0, a2[31:10]};
    s = {2'b00, a16} + {2'b00, f} + {2'b00, a7} + {2'b00, n};
    return s[31:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic drive(input bit v, input logic [31:0] a2, input logic [31:0] a7,
                       input logic [31:0] a15, input logic [31:0] a16, input string req);
    exp_t e;
    @(negedge clk);
    in_valid = v; w_m2 = a2; w_m7 = a7; w_m15 = a15; w_m16 = a16;
    if (v) begin
      e.word = ref_word(a2, a7, a15, a16);
      e.tag  = cyc + 1;
      e.req  = req;
      q3.push_back(e);
      q1.push_back(e);
    end
  endtask

  // monitor: compare at negedges
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (ov3 === 1'b1) begin
        if (q3.size() == 0) check(1'b0, "R6 lat3 unexpected valid", 32'd0, 32'd0);
        else begin
          exp_t e;
          e = q3.pop_front();
          check(wn3 === e.word, {e.req, " lat3 word"}, wn3, e.word);
          // R4
          check(cyc - e.tag == 2, "R4 lat3 timing", cyc - e.tag, 2);
        end
      end
      if (ov1 === 1'b1) begin
        if (q1.size() == 0) check(1'b0, "R6 lat1 unexpected valid", 32'd0, 32'd0);
        else begin
          exp_t e;
          e = q1.pop_front();
          check(wn1 === e.word, {e.req, " lat1 word"}, wn1, e.word);
          // R4
          check(cyc - e.tag == 0, "R4 lat1 timing", cyc - e.tag, 0);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0;
    w_m2 = '0; w_m7 = '0; w_m15 = '0; w_m16 = '0;
    repeat (3) @(negedge clk);
    // R7 reset state
    check(ov3 === 1'b0, "R7 reset lat3 valid", {31'd0, ov3}, 32'd0);
    check(ov1 === 1'b0, "R7 reset lat1 valid", {31'd0, ov1}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 sigma on word fifteen back alone
    drive(1, 32'h0, 32'h0, 32'h0000_0001, 32'h0, "R1");
    drive(1, 32'h0, 32'h0, 32'h8000_0000, 32'h0, "R1");
    drive(1, 32'h0, 32'h0, 32'hDEAD_BEEF, 32'h0, "R1");
    // R2 sigma on word two back alone
    drive(1, 32'h0000_0001, 32'h0, 32'h0, 32'h0, "R2");
    drive(1, 32'h8000_0400, 32'h0, 32'h0, 32'h0, "R2");
    drive(1, 32'h1234_5678, 32'h0, 32'h0, 32'h0, "R2");
    // R3 carry wraparound
    drive(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
    drive(1, 32'h0, 32'h0, 32'h0, 32'h0, "R3");
    drive(1, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0000_0001, "R3");
    // R5 back-to-back random sets
    for (int i = 0; i < 200; i++)
      drive(1, $urandom, $urandom, $urandom, $urandom, "R5");
    // R6 sparse valid pattern
    for (int i = 0; i < 120; i++)
      drive(($urandom % 3) == 0, $urandom, $urandom, $urandom, $urandom, "R6");
    drive(0, 32'h0, 32'h0, 32'h0, 32'h0, "R6");
    repeat (5) @(negedge clk);
    check(q3.size() == 0, "R6 lat3 drained", q3.size(), 0);
    check(q1.size() == 0, "R6 lat1 drained", q1.size(), 0);

    // R7 reset with items in flight
    drive(1, $urandom, $urandom, $urandom, $urandom, "R7");
    drive(1, $urandom, $urandom, $urandom, $urandom, "R7");
    #1;
    in_valid = 1'b0;
    rst_n = 1'b0;
    #0.5;
    check(ov3 === 1'b0, "R7 async clear lat3", {31'd0, ov3}, 32'd0);
    check(ov1 === 1'b0, "R7 async clear lat1", {31'd0, ov1}, 32'd0);
    q3.delete();
    q1.delete();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(ov3 === 1'b0, "R7 no stale output lat3", {31'd0, ov3}, 32'd0);
    check(ov1 === 1'b0, "R7 no stale output lat1", {31'd0, ov1}, 32'd0);

    // R4 single item after idle
    drive(1, 32'hA5A5_5A5A, 32'h0F0F_F0F0, 32'h3333_CCCC, 32'h7777_8888, "R4");
    drive(0, 32'h0, 32'h0, 32'h0, 32'h0, "R4");
    repeat (5) @(negedge clk);
    check(q3.size() == 0, "R4 lat3 drained", q3.size(), 0);
    check(q1.size() == 0, "R4 lat1 drained", q1.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule